// File: doc/BRIEF.md
# I2S Serial Audio Transmitter with Sample Queue

This block sends audio to an external converter over a three-wire I2S link: bit clock, word select and serial data. Software sets it up through a small 32-bit register window. One field gives the sample width. Two fields set a two-stage clock division. The first divides a master-clock tick (a one-cycle enable pulse in the system clock domain) down to the bit clock. The second sets how many bit clocks make up one stereo frame.

Samples enter as 32-bit words written to a data register. Each word carries one channel's sample in its low bits, and words alternate left, right, left. The words are queued in a 32-entry FIFO. Each sample goes out MSB first in its half of the frame, starting one bit clock after word select changes. Unused bit slots are sent as zero.

The sample path has no handshake. Back-pressure is polled instead. Software reads the fill level and writes only while it is below 32. A write made while the FIFO is full is dropped and sets a sticky flag. If the FIFO is empty when a slot starts, the block sends zeros and sets another sticky flag. A receive enable bit and a receive width register are kept so software can read them back, but they drive nothing.

Top module: `i2s_tx_ctrl`

## Requirements
- R1: After reset the registers read as follows: sample-width 0x0F, receive-width 0x0F, clock 0x0007001F, level 0, flags 0, enable 0. The outputs `sclk_o`, `ws_o` and `sd_o` are low.
- R2: The register map uses byte addresses. 0x00 is the sample width minus one, in bits [4:0]. 0x04 is the receive width, in bits [4:0]. 0x08 is the clock register: bits [23:16] hold master ticks per bit clock minus one (must be at least 1), and bits [7:0] hold bit clocks per frame minus one. 0x0C is the level, in bits [5:0]. 0x18 holds the flags. 0x1C is the enable register: bit 0 enables transmit and bit 1 enables receive. 0x20 is the clear register. 0x24 is the data register. Any other address reads 0 and ignores writes.
- R3: Each write to 0x24 queues one word while the FIFO holds fewer than 32 words. The level register counts the queued words, from 0 to 32.
- R4: A write to 0x24 while the level is 32 is dropped. It sets flag bit 1 (overrun). Writing 1 to flag bit 1 clears it.
- R5: While transmit is enabled, one bit clock period lasts exactly D+1 master ticks, where D is clock register bits [23:16].
- R6: A frame lasts F+1 bit clocks, where F is clock register bits [7:0]. Word select is low for the left half and high for the right half, and the right half starts at bit (F+1)/2. Word select changes one bit clock before each half starts.
- R7: Each half sends the low W bits of its word (W = width field + 1), MSB first. The first bit is sent one bit clock after word select changes. The remaining bits of the half are zero. Words are taken in order, left first.
- R8: If the FIFO is empty when a half starts, that half sends zeros and flag bit 0 (underrun) is set. Writing 1 to flag bit 0 clears it.
- R9: Any write to 0x20 empties the FIFO and restarts the framing. The flags keep their values.
- R10: While transmit is disabled, `sclk_o`, `ws_o` and `sd_o` stay low and the FIFO is not drained.
- R11: The receive enable bit and the receive width register read back as written. They have no effect on the serial outputs or the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_tick | input | 1 | One-cycle master-clock enable pulse |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on `reg_addr` |
| sclk_o | output | 1 | I2S bit clock |
| ws_o | output | 1 | I2S word select (0 = left) |
| sd_o | output | 1 | I2S serial data |

## Verification
The assertions check a set of invariants on every cycle:
- the level never exceeds 32 and moves by at most one word per cycle, except when the FIFO is cleared;
- a clear empties the FIFO;
- a write to a full FIFO sets the overrun flag, and a slot that starts with the FIFO empty sets the underrun flag;
- word select and data hold between bit advances;
- the outputs are quiet while transmit is disabled.

The bench scenarios are the only place where the serial stream itself is checked. They decode the stream at bit-clock rising edges and compare it with frames built from the queued words. This covers:
- bit ordering, width truncation, zero padding and the placement of word select;
- the tick count of each bit clock;
- polled streaming of more than 32 words;
- read-back of the register map.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int unsigned BUS_AW = 6;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_TXFMT  = 6'h00;
  localparam logic [BUS_AW-1:0] OFS_RXFMT  = 6'h04;
  localparam logic [BUS_AW-1:0] OFS_CLK    = 6'h08;
  localparam logic [BUS_AW-1:0] OFS_LEVEL  = 6'h0C;
  localparam logic [BUS_AW-1:0] OFS_FLAGS  = 6'h18;
  localparam logic [BUS_AW-1:0] OFS_RUN    = 6'h1C;
  localparam logic [BUS_AW-1:0] OFS_FLUSH  = 6'h20;
  localparam logic [BUS_AW-1:0] OFS_TXDATA = 6'h24;

  localparam int unsigned FLAG_STARVE = 0;
  localparam int unsigned FLAG_DROP   = 1;
  localparam int unsigned RUN_TX      = 0;
  localparam int unsigned RUN_RX      = 1;

  localparam int unsigned WW = 5;  // width-minus-one field
  localparam int unsigned CW = 8;  // divider fields

  typedef struct packed {
    logic [WW-1:0] width_m1;
    logic [CW-1:0] bit_div;
    logic [CW-1:0] frame_div;
  } txcfg_t;
endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);
  localparam logic [LW-1:0] FULL_L = LW'(DEPTH);
  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full     = (cnt == FULL_L);
  assign empty    = (cnt == '0);
  assign do_push  = push & ~full;
  assign do_pop   = pop & ~empty;
  assign pop_data = mem[rptr];
  assign level    = cnt;

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/i2s_tx_bitclk.sv
module i2s_tx_bitclk #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] bit_div,
  output logic          sclk,
  output logic          bit_adv
);
  logic [CW-1:0] mcnt;
  logic          wrap;

  assign wrap    = (mcnt >= bit_div);
  assign bit_adv = run & ~restart & tick & wrap;
  // low for the first half of the period, high for the rest; data moves on the falling edge
  assign sclk    = run & (mcnt > (bit_div >> 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) mcnt <= '0;
    else if (tick) mcnt <= wrap ? '0 : mcnt + 1'b1;
  end
endmodule

// File: rtl/i2s_tx_framer.sv
module i2s_tx_framer #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 8,
  parameter int unsigned WW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic          bit_adv,
  input  logic [WW-1:0] width_m1,
  input  logic [CW-1:0] frame_div,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          slot_load,
  output logic          pop,
  output logic          ws_o,
  output logic          sd_o
);
  localparam logic [WW-1:0] TOP_BIT = WW'(DW - 1);

  logic [CW-1:0] bcnt, bcnt_n;
  logic [CW:0]   half, ws_from;
  logic [DW-1:0] sr, aligned;
  logic          ws_n;

  assign half      = ({1'b0, frame_div} + 1'b1) >> 1;
  assign ws_from   = half - 1'b1;
  assign bcnt_n    = (bcnt >= frame_div) ? '0 : bcnt + 1'b1;
  assign slot_load = bit_adv & ((bcnt_n == '0) | ({1'b0, bcnt_n} == half));
  assign pop       = slot_load & ~fifo_empty;
  assign aligned   = fifo_empty ? '0 : (fifo_data << (TOP_BIT - width_m1));
  assign ws_n      = ({1'b0, bcnt_n} >= ws_from) && (bcnt_n != frame_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= '0;
      sr   <= '0;
      sd_o <= 1'b0;
      ws_o <= 1'b0;
    end else if (!run || restart) begin
      bcnt <= frame_div;  // park on the last bit so the first advance opens a frame
      sr   <= '0;
      sd_o <= 1'b0;
      ws_o <= 1'b0;
    end else if (bit_adv) begin
      bcnt <= bcnt_n;
      ws_o <= ws_n;
      if (slot_load) begin
        sd_o <= aligned[DW-1];
        sr   <= aligned << 1;
      end else begin
        sd_o <= sr[DW-1];
        sr   <= sr << 1;
      end
    end
  end
endmodule

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mclk_tick,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk_o,
  output logic        ws_o,
  output logic        sd_o
);
  import i2s_tx_pkg::*;

  txcfg_t        cfg_q;
  logic [WW-1:0] rxw_q;
  logic [1:0]    run_q;
  logic          starve_q, drop_q;
  logic          tx_en;
  logic          wr_hit, wr_txfmt, wr_rxfmt, wr_clk, wr_flags, wr_run, wr_flush, wr_txdata;
  logic          fifo_empty, fifo_full, fifo_pop, slot_load, bit_adv;
  logic [31:0]   fifo_head;
  logic [LW-1:0] fifo_level;
  logic          unused_wdata;

  assign unused_wdata = ^{reg_wdata[31:24], reg_wdata[15:8]};
  assign tx_en     = run_q[RUN_TX];
  assign wr_hit    = reg_sel & reg_wr;
  assign wr_txfmt  = wr_hit && (reg_addr == OFS_TXFMT);
  assign wr_rxfmt  = wr_hit && (reg_addr == OFS_RXFMT);
  assign wr_clk    = wr_hit && (reg_addr == OFS_CLK);
  assign wr_flags  = wr_hit && (reg_addr == OFS_FLAGS);
  assign wr_run    = wr_hit && (reg_addr == OFS_RUN);
  assign wr_flush  = wr_hit && (reg_addr == OFS_FLUSH);
  assign wr_txdata = wr_hit && (reg_addr == OFS_TXDATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '{width_m1: WW'(15), bit_div: CW'(7), frame_div: CW'(31)};
      rxw_q <= WW'(15);
      run_q <= '0;
    end else begin
      if (wr_txfmt) cfg_q.width_m1 <= reg_wdata[WW-1:0];
      if (wr_rxfmt) rxw_q <= reg_wdata[WW-1:0];
      if (wr_clk) begin
        cfg_q.bit_div   <= reg_wdata[16 +: CW];
        cfg_q.frame_div <= reg_wdata[0 +: CW];
      end
      if (wr_run) run_q <= reg_wdata[1:0];
    end
  end

  // sticky flags: a new event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      starve_q <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      starve_q <= (starve_q & ~(wr_flags & reg_wdata[FLAG_STARVE]))
                | (slot_load & fifo_empty);
      drop_q   <= (drop_q & ~(wr_flags & reg_wdata[FLAG_DROP]))
                | (wr_txdata & fifo_full);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_TXFMT: reg_rdata[WW-1:0] = cfg_q.width_m1;
      OFS_RXFMT: reg_rdata[WW-1:0] = rxw_q;
      OFS_CLK: begin
        reg_rdata[16 +: CW] = cfg_q.bit_div;
        reg_rdata[0 +: CW]  = cfg_q.frame_div;
      end
      OFS_LEVEL: reg_rdata[LW-1:0] = fifo_level;
      OFS_FLAGS: begin
        reg_rdata[FLAG_STARVE] = starve_q;
        reg_rdata[FLAG_DROP]   = drop_q;
      end
      OFS_RUN:   reg_rdata[1:0] = run_q;
      default:   reg_rdata = '0;
    endcase
  end

  i2s_tx_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(wr_flush),
    .push(wr_txdata), .push_data(reg_wdata),
    .pop(fifo_pop), .pop_data(fifo_head),
    .level(fifo_level), .empty(fifo_empty), .full(fifo_full)
  );

  i2s_tx_bitclk #(.CW(CW)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .run(tx_en), .restart(wr_flush),
    .tick(mclk_tick), .bit_div(cfg_q.bit_div),
    .sclk(sclk_o), .bit_adv(bit_adv)
  );

  i2s_tx_framer #(.DW(32), .CW(CW), .WW(WW)) u_framer (
    .clk(clk), .rst_n(rst_n), .run(tx_en), .restart(wr_flush),
    .bit_adv(bit_adv), .width_m1(cfg_q.width_m1), .frame_div(cfg_q.frame_div),
    .fifo_empty(fifo_empty), .fifo_data(fifo_head),
    .slot_load(slot_load), .pop(fifo_pop), .ws_o(ws_o), .sd_o(sd_o)
  );
endmodule

// File: rtl/i2s_tx_ctrl_chk.sv
module i2s_tx_ctrl_chk #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          data_wr,
  input logic          flush,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic [LW-1:0] level,
  input logic          slot_load,
  input logic          bit_adv,
  input logic          starve,
  input logic          drop,
  input logic          sclk_o,
  input logic          ws_o,
  input logic          sd_o
);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
  localparam logic [LW-1:0] ONE_L   = LW'(1);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) level <= DEPTH_L); // R3
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (level == $past(level) || level == $past(level) + ONE_L || level + ONE_L == $past(level))); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) data_wr && fifo_full |=> drop); // R4
  AST_STARVE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) slot_load && fifo_empty |=> starve); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> level == '0); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !tx_en |=> !ws_o && !sd_o && !sclk_o); // R10
  AST_HOLD_BETWEEN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && !bit_adv && !flush |=> $stable(ws_o) && $stable(sd_o)); // R6
endmodule

bind i2s_tx_ctrl i2s_tx_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .data_wr(wr_txdata), .flush(wr_flush),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .level(fifo_level),
  .slot_load(slot_load), .bit_adv(bit_adv), .starve(starve_q), .drop(drop_q),
  .sclk_o(sclk_o), .ws_o(ws_o), .sd_o(sd_o)
);

// File: tb/i2s_tx_ctrl_tb.sv
module i2s_tx_ctrl_tb;
  import i2s_tx_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 4096;

  logic        clk = 1'b0, rst_n = 1'b0, mclk_tick = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk_o, ws_o, sd_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_tx_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mclk_tick(mclk_tick),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk_o(sclk_o), .ws_o(ws_o), .sd_o(sd_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // random master tick, about two thirds of cycles
  always @(negedge clk) mclk_tick <= ($urandom_range(2, 0) != 0);

  int tc = 0;
  always @(posedge clk) if (mclk_tick) tc++;

  // stream capture at bit-clock rising edges
  bit cap_ws [MAXB];
  bit cap_sd [MAXB];
  bit exp_ws [MAXB];
  bit exp_sd [MAXB];
  int cap_n = 0, per_bad = 0, exp_per = 8, last_tc = 0;
  bit cap_on = 0, seen = 0;
  logic sclk_prev = 1'b0;
  always @(negedge clk) begin
    if (cap_on && sclk_o && !sclk_prev) begin
      if (cap_n < MAXB) begin
        cap_ws[cap_n] = ws_o;
        cap_sd[cap_n] = sd_o;
      end
      cap_n++;
      if (seen && (tc - last_tc != exp_per)) per_bad++;
      last_tc = tc;
      seen = 1;
    end
    sclk_prev = sclk_o;
  end

  logic [31:0] wbuf [64];

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  // expected stream: one idle bit, then frames built from the queued words
  task automatic build_exp(input int nf, input int w, input int fd, output int nbits);
    int half;
    half = (fd + 1) / 2;
    nbits = 1 + nf * (fd + 1);
    exp_ws[0] = 0;
    exp_sd[0] = 0;
    for (int f = 0; f < nf; f++) begin
      for (int p = 0; p <= fd; p++) begin
        int idx, q, ch;
        logic [31:0] word;
        idx = 1 + f * (fd + 1) + p;
        ch  = (p < half) ? 0 : 1;
        q   = (p < half) ? p : p - half;
        word = wbuf[2 * f + ch];
        exp_ws[idx] = (p >= half - 1) && (p != fd);
        exp_sd[idx] = (q < w) ? word[w - 1 - q] : 1'b0;
      end
    end
  endtask

  task automatic run_scn(input string tag, input int w, input int mdiv, input int fdiv,
                         input int nw, input bit directed);
    int nbits, bad_ws, bad_sd, pre;
    logic [31:0] rd;
    bus_wr(OFS_FLUSH, 32'h0);
    bus_wr(OFS_TXFMT, 32'(w - 1));
    bus_wr(OFS_CLK, (32'(mdiv) << 16) | 32'(fdiv));
    for (int i = 0; i < nw; i++)
      wbuf[i] = directed ? ((i % 2 == 0) ? 32'hFFFF_FFFF : 32'h0000_0001 << (i % 24)) : $urandom;
    build_exp(nw / 2, w, fdiv, nbits);
    pre = (nw < 32) ? nw : 32;
    for (int i = 0; i < pre; i++) bus_wr(OFS_TXDATA, wbuf[i]);
    cap_n = 0; per_bad = 0; seen = 0; exp_per = mdiv + 1;
    cap_on = 1;
    bus_wr(OFS_RUN, 32'h1);
    for (int i = pre; i < nw; i++) begin
      do bus_rd(OFS_LEVEL, rd); while (rd >= 32);
      bus_wr(OFS_TXDATA, wbuf[i]);
    end
    while (cap_n < nbits) @(negedge clk);
    cap_on = 0;
    bus_wr(OFS_RUN, 32'h0);
    bad_ws = 0; bad_sd = 0;
    for (int k = 0; k < nbits; k++) begin
      if (cap_ws[k] != exp_ws[k]) bad_ws++;
      if (cap_sd[k] != exp_sd[k]) bad_sd++;
    end
    check({tag, " R6 word-select mismatches"}, 32'(bad_ws), 0);
    check({tag, " R7 data mismatches"}, 32'(bad_sd), 0);
    check({tag, " R5 bit-clock period errors"}, 32'(per_bad), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int zeros;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(OFS_TXFMT, rd); check("R1 sample width", rd, 32'h0F);
    bus_rd(OFS_RXFMT, rd); check("R1 receive width", rd, 32'h0F);
    bus_rd(OFS_CLK, rd);   check("R1 clock reg", rd, 32'h0007_001F);
    bus_rd(OFS_LEVEL, rd); check("R1 level", rd, 0);
    bus_rd(OFS_FLAGS, rd); check("R1 flags", rd, 0);
    bus_rd(OFS_RUN, rd);   check("R1 enable", rd, 0);
    check("R1 outputs", {29'b0, sclk_o, ws_o, sd_o}, 0);

    // R2 map: unmapped addresses
    bus_wr(6'h10, 32'hFFFF_FFFF);
    bus_rd(6'h10, rd); check("R2 unmapped 0x10", rd, 0);
    bus_rd(6'h28, rd); check("R2 unmapped 0x28", rd, 0);
    bus_wr(OFS_CLK, 32'hAB03_CD2F);
    bus_rd(OFS_CLK, rd); check("R2 clock fields", rd, 32'h0003_002F);

    // R3 / R4 fill and overrun
    for (int i = 0; i < 5; i++) bus_wr(OFS_TXDATA, $urandom);
    bus_rd(OFS_LEVEL, rd); check("R3 level after 5", rd, 5);
    for (int i = 5; i < 32; i++) bus_wr(OFS_TXDATA, $urandom);
    bus_rd(OFS_LEVEL, rd); check("R3 level full", rd, 32);
    bus_wr(OFS_TXDATA, 32'h1234_5678);
    bus_rd(OFS_LEVEL, rd); check("R4 level after drop", rd, 32);
    bus_rd(OFS_FLAGS, rd); check("R4 overrun flag", rd, 32'h2);

    // R9 clear keeps flags
    bus_wr(OFS_FLUSH, 32'h0);
    bus_rd(OFS_LEVEL, rd); check("R9 level after clear", rd, 0);
    bus_rd(OFS_FLAGS, rd); check("R9 flags kept", rd, 32'h2);
    bus_wr(OFS_FLAGS, 32'h2);
    bus_rd(OFS_FLAGS, rd); check("R4 overrun cleared", rd, 0);

    // R10 disabled: nothing moves
    for (int i = 0; i < 3; i++) bus_wr(OFS_TXDATA, $urandom);
    cap_n = 0; cap_on = 1;
    repeat (100) @(negedge clk);
    check("R10 no bit clock", 32'(cap_n), 0);
    bus_rd(OFS_LEVEL, rd); check("R10 fifo not drained", rd, 3);

    // R11 receive stub
    bus_wr(OFS_RUN, 32'h2);
    bus_wr(OFS_RXFMT, 32'h17);
    bus_rd(OFS_RUN, rd);   check("R11 rx enable readback", rd, 32'h2);
    bus_rd(OFS_RXFMT, rd); check("R11 rx width readback", rd, 32'h17);
    repeat (100) @(negedge clk);
    check("R11 no serial activity", {29'b0, sclk_o, ws_o, sd_o} | 32'(cap_n), 0);
    bus_rd(OFS_LEVEL, rd); check("R11 fifo untouched", rd, 3);
    cap_on = 0;
    bus_wr(OFS_RUN, 32'h0);

    // serial scenarios
    run_scn("s16 directed", 16, 7, 31, 8, 1'b1);
    run_scn("s24 random", 24, 3, 47, 10, 1'b0);
    run_scn("s24 padded", 24, 1, 63, 8, 1'b0);
    run_scn("s16 streamed", 16, 3, 31, 48, 1'b0);

    // R8 underrun
    bus_wr(OFS_FLUSH, 32'h0);
    bus_wr(OFS_FLAGS, 32'h3);
    bus_wr(OFS_CLK, 32'h0001_001F);
    cap_n = 0; seen = 0; per_bad = 0; exp_per = 2; cap_on = 1;
    bus_wr(OFS_RUN, 32'h1);
    while (cap_n < 40) @(negedge clk);
    cap_on = 0;
    bus_wr(OFS_RUN, 32'h0);
    zeros = 0;
    for (int k = 0; k < 40; k++) if (cap_sd[k]) zeros++;
    check("R8 zeros while empty (ones seen)", 32'(zeros), 0);
    bus_rd(OFS_FLAGS, rd); check("R8 underrun flag", rd & 32'h1, 32'h1);
    bus_wr(OFS_FLAGS, 32'h1);
    bus_rd(OFS_FLAGS, rd); check("R8 underrun cleared", rd, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule